// File: doc/BRIEF.md
# Prescaled Multi-Width Timer Counter

A synchronous timer/counter driven by one clock. It counts at a programmable prescaled rate, and its width can be 8, 16 or 32 bits. It can count up or down. It runs either without end or as a one-shot that halts after a single wrap. When counting up it returns to zero after reaching its top value. When counting down it reloads the top value after passing zero. Both wraps raise a one-cycle overflow pulse.

Software controls the block through a small write-only register port. Address 0 holds the configuration word. Address 1 takes commands. Address 2 loads the count directly. Address 3 holds the period that sets the top value in 8-bit mode.

Commands can force a start or retrigger, or force a stop. A retrigger takes effect under one of three rules:
- on the next clock edge;
- on the next prescaled tick;
- on the next clock edge, with the prescaler phase cleared at the same time.

A level `enable` input gates all counting. A `soft_rst` pulse returns the counter and every control field to zero.

Top module: `prescaled_timer`

## Requirements
- R1: Configuration bits [1:0] select the width: 0 = 16-bit, 1 = 8-bit, 2 = 32-bit (3 behaves as 16-bit). Counting up, the count wraps after 0xFFFF in 16-bit mode and after 0xFFFFFFFF in 32-bit mode.
- R2: Configuration bits [4:2] select the tick divider. Codes 0..7 divide by 1, 2, 4, 8, 16, 64, 256 and 1024. The counter moves at most once per tick.
- R3: Configuration bit 7 selects the direction: 0 counts up, 1 counts down. An up wrap loads 0. A down step from 0 loads the top value. Either wrap drives `ovf_o` high for exactly that cycle.
- R4: In 8-bit mode the top value is the period register at address 3. A count at or above it wraps to 0 on the next up tick.
- R5: When configuration bit 8 (one-shot) is set, the counter sets `stopped_o` at the wrap. It then holds the wrapped value.
- R6: Writing 1 to address 1 bits [1:0] retriggers: it loads 0 when counting up and the top value when counting down, and clears `stopped_o`. Writing 2 there stops the counter, which then holds its value.
- R7: Command code 3 changes neither the count nor `stopped_o`.
- R8: Configuration bits [6:5] select when a retrigger applies. Code 0 applies it on the next clock edge. Code 1 applies it on the next prescaled tick. Code 2 applies it on the next clock edge and also restarts the prescaler phase, so the first step comes a full divider period later. Code 3 behaves as code 0.
- R9: A `soft_rst` pulse clears the count, `stopped_o`, `ovf_o`, the prescaler, the configuration and the period on the next edge.
- R10: While `enable` is low, the prescaler and the count do not advance and `ovf_o` stays low.
- R11: A write to address 2 loads the count on the next edge. The value is masked to the current width.
- R12: After `rst`, the count is 0 and `stopped_o` and `ovf_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| soft_rst | input | 1 | Synchronous software reset of all control state |
| enable | input | 1 | Counting enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 32 | Register write data |
| count_o | output | 32 | Current count value |
| stopped_o | output | 1 | High while the counter is halted |
| ovf_o | output | 1 | One-cycle overflow/underflow pulse |

## Verification
A sweep over all eight divider codes with a short 8-bit period measures the spacing between overflow pulses. This separates every divider value, including the gaps where divide-by-32 and divide-by-128 are missing.

Each width is started two steps below its wrap point, both up and down, to show where that width's top lies. The three retrigger timing rules are started from a known prescaler phase, so each rule produces a different cycle for the first step.

Stop, retrigger, the ignored code and one-shot runs are checked by watching the count stay fixed or resume. Software reset and enable are checked the same way.

// File: rtl/ptm_pkg.sv
`timescale 1ns/1ps
package ptm_pkg;

  typedef enum logic [1:0] {
    WM_16  = 2'd0,
    WM_8   = 2'd1,
    WM_32  = 2'd2,
    WM_RSV = 2'd3
  } width_mode_e;

  typedef enum logic [1:0] {
    SY_EDGE   = 2'd0,
    SY_TICK   = 2'd1,
    SY_RESYNC = 2'd2,
    SY_RSV    = 2'd3
  } sync_e;

  typedef enum logic [1:0] {
    CM_NONE   = 2'd0,
    CM_RETRIG = 2'd1,
    CM_STOP   = 2'd2,
    CM_RSV    = 2'd3
  } cmd_e;

  // Configuration word, msb first: oneshot[8] down[7] sync[6:5] presc[4:2] width[1:0]
  typedef struct packed {
    logic        oneshot;
    logic        down;
    sync_e       sync;
    logic [2:0]  presc;
    width_mode_e width;
  } cfg_t;

  localparam int CFG_BITS = $bits(cfg_t);

  localparam int A_CFG    = 0;
  localparam int A_CMD    = 1;
  localparam int A_COUNT  = 2;
  localparam int A_PERIOD = 3;

  // Divider exponent per prescaler code (no /32, no /128)
  function automatic int unsigned presc_shift(input logic [2:0] code);
    case (code)
      3'd5:    return 6;
      3'd6:    return 8;
      3'd7:    return 10;
      default: return int'(code);
    endcase
  endfunction

endpackage

// File: rtl/ptm_prescaler.sv
`timescale 1ns/1ps
module ptm_prescaler
  import ptm_pkg::*;
#(
  parameter int PS_W = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       soft_rst,
  input  logic       run,
  input  logic       clr,
  input  logic [2:0] code,
  output logic       tick
);

  logic [PS_W-1:0] ps_cnt;
  logic [PS_W-1:0] lim;

  always_comb begin
    lim  = PS_W'((32'd1 << presc_shift(code)) - 32'd1);
    tick = run && (ps_cnt >= lim);
  end

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      ps_cnt <= '0;
    end else if (clr) begin
      ps_cnt <= '0;
    end else if (run) begin
      if (tick) ps_cnt <= '0;
      else      ps_cnt <= ps_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/ptm_regs.sv
`timescale 1ns/1ps
module ptm_regs
  import ptm_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int PER_W  = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  output cfg_t              cfg,
  output logic [PER_W-1:0]  period,
  output logic              cnt_wr,
  output logic [CNT_W-1:0]  cnt_wdata,
  output logic              cmd_retrig,
  output logic              cmd_stop
);

  logic sel;
  cmd_e cmd;

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      cfg    <= '0;
      period <= '0;
    end else if (wr_en) begin
      if (wr_addr == ADDR_W'(A_CFG))    cfg    <= cfg_t'(wr_data[CFG_BITS-1:0]);
      if (wr_addr == ADDR_W'(A_PERIOD)) period <= wr_data[PER_W-1:0];
    end
  end

  always_comb begin
    sel        = wr_en && !soft_rst;
    cmd        = cmd_e'(wr_data[1:0]);
    cnt_wr     = sel && (wr_addr == ADDR_W'(A_COUNT));
    cnt_wdata  = wr_data;
    cmd_retrig = sel && (wr_addr == ADDR_W'(A_CMD)) && (cmd == CM_RETRIG);
    cmd_stop   = sel && (wr_addr == ADDR_W'(A_CMD)) && (cmd == CM_STOP);
  end

endmodule

// File: rtl/ptm_counter.sv
`timescale 1ns/1ps
module ptm_counter
  import ptm_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int PER_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             soft_rst,
  input  width_mode_e      width,
  input  logic             down,
  input  logic             oneshot,
  input  sync_e            sync,
  input  logic [PER_W-1:0] period,
  input  logic             tick,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             retrig,
  input  logic             stop,
  output logic [CNT_W-1:0] count,
  output logic             stopped,
  output logic             ovf,
  output logic             pend
);

  localparam logic [CNT_W-1:0] MASK8  = {{(CNT_W-8){1'b0}},  {8{1'b1}}};
  localparam logic [CNT_W-1:0] MASK16 = {{(CNT_W-16){1'b0}}, {16{1'b1}}};
  localparam logic [CNT_W-1:0] MASK32 = {CNT_W{1'b1}};

  logic [CNT_W-1:0] mask;
  logic [CNT_W-1:0] top;
  logic [CNT_W-1:0] load;
  logic             retrig_now;

  always_comb begin
    case (width)
      WM_8:    begin mask = MASK8;  top = {{(CNT_W-PER_W){1'b0}}, period}; end
      WM_32:   begin mask = MASK32; top = MASK32; end
      default: begin mask = MASK16; top = MASK16; end
    endcase
    load       = down ? top : '0;
    retrig_now = retrig && (sync != SY_TICK);
  end

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      count   <= '0;
      stopped <= 1'b0;
      ovf     <= 1'b0;
      pend    <= 1'b0;
    end else begin
      ovf <= 1'b0;
      if (cnt_wr) begin
        count <= cnt_wdata & mask;
      end else if (retrig_now) begin
        count   <= load;
        stopped <= 1'b0;
        pend    <= 1'b0;
      end else if (retrig) begin
        pend <= 1'b1;
      end else if (stop) begin
        stopped <= 1'b1;
        pend    <= 1'b0;
      end else if (tick) begin
        if (pend) begin
          count   <= load;
          stopped <= 1'b0;
          pend    <= 1'b0;
        end else if (!stopped) begin
          if (!down) begin
            if (count >= top) begin
              count   <= '0;
              ovf     <= 1'b1;
              stopped <= oneshot;
            end else begin
              count <= count + 1'b1;
            end
          end else begin
            if (count == '0) begin
              count   <= top;
              ovf     <= 1'b1;
              stopped <= oneshot;
            end else begin
              count <= count - 1'b1;
            end
          end
        end
      end
    end
  end

endmodule

// File: rtl/prescaled_timer.sv
`timescale 1ns/1ps
module prescaled_timer
  import ptm_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int PER_W  = 8,
  parameter int PS_W   = 10,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_rst,
  input  logic              enable,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  output logic [CNT_W-1:0]  count_o,
  output logic              stopped_o,
  output logic              ovf_o
);

  cfg_t             cfg;
  logic [PER_W-1:0] period;
  logic             cnt_wr;
  logic [CNT_W-1:0] cnt_wdata;
  logic             cmd_retrig;
  logic             cmd_stop;
  logic             tick;
  logic             pend;
  logic             ps_clr;

  assign ps_clr = cmd_retrig && (cfg.sync == SY_RESYNC);

  ptm_regs #(.CNT_W(CNT_W), .PER_W(PER_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .soft_rst(soft_rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cfg(cfg), .period(period), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
    .cmd_retrig(cmd_retrig), .cmd_stop(cmd_stop)
  );

  ptm_prescaler #(.PS_W(PS_W)) u_presc (
    .clk(clk), .rst(rst), .soft_rst(soft_rst),
    .run(enable), .clr(ps_clr), .code(cfg.presc), .tick(tick)
  );

  ptm_counter #(.CNT_W(CNT_W), .PER_W(PER_W)) u_cnt (
    .clk(clk), .rst(rst), .soft_rst(soft_rst),
    .width(cfg.width), .down(cfg.down), .oneshot(cfg.oneshot), .sync(cfg.sync),
    .period(period), .tick(tick),
    .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
    .retrig(cmd_retrig), .stop(cmd_stop),
    .count(count_o), .stopped(stopped_o), .ovf(ovf_o), .pend(pend)
  );

endmodule

// File: rtl/ptm_checker.sv
`timescale 1ns/1ps
module ptm_checker
  import ptm_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int PER_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             soft_rst,
  input logic             enable,
  input logic             wr_en,
  input logic [CNT_W-1:0] count_o,
  input logic             stopped_o,
  input logic             ovf_o,
  input logic             tick,
  input logic             pend,
  input cfg_t             cfg,
  input logic [PER_W-1:0] period
);

  assert_soft_reset_clears_R9: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> (count_o == '0) && !stopped_o && !ovf_o);

  assert_ovf_on_tick_R2: assert property (@(posedge clk) disable iff (rst)
    ovf_o |-> $past(tick));

  assert_up_wrap_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (ovf_o && !$past(cfg.down)) |-> (count_o == '0));

  assert_down_wrap_period_R4: assert property (@(posedge clk) disable iff (rst)
    (ovf_o && $past(cfg.down) && ($past(cfg.width) == WM_8))
      |-> (count_o == {{(CNT_W-PER_W){1'b0}}, $past(period)}));

  assert_oneshot_halts_R5: assert property (@(posedge clk) disable iff (rst)
    (ovf_o && $past(cfg.oneshot)) |-> stopped_o);

  assert_stop_holds_R6: assert property (@(posedge clk) disable iff (rst)
    (stopped_o && !pend && !wr_en && !soft_rst) |=> $stable(count_o));

  assert_disabled_frozen_R10: assert property (@(posedge clk) disable iff (rst)
    (!enable && !wr_en && !soft_rst && !pend) |=> ($stable(count_o) && !ovf_o));

endmodule

bind prescaled_timer ptm_checker #(.CNT_W(CNT_W), .PER_W(PER_W)) u_chk (
  .clk(clk), .rst(rst), .soft_rst(soft_rst), .enable(enable), .wr_en(wr_en),
  .count_o(count_o), .stopped_o(stopped_o), .ovf_o(ovf_o),
  .tick(tick), .pend(pend), .cfg(cfg), .period(period)
);

// File: tb/prescaled_timer_tb.sv
`timescale 1ns/1ps
module prescaled_timer_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        soft_rst = 1'b0;
  logic        enable = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] count_o;
  logic        stopped_o;
  logic        ovf_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  prescaled_timer dut_i (
    .clk(clk), .rst(rst), .soft_rst(soft_rst), .enable(enable),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .count_o(count_o), .stopped_o(stopped_o), .ovf_o(ovf_o)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", rq, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step(1);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic sreset();
    enable = 1'b0;
    soft_rst = 1'b1;
    step(1);
    soft_rst = 1'b0;
  endtask

  function automatic logic [31:0] mkcfg(input int width, input int presc, input int sync,
                                        input bit down, input bit os);
    return (32'(os) << 8) | (32'(down) << 7) | (32'(sync) << 5) | (32'(presc) << 2) | 32'(width);
  endfunction

  function automatic int divof(input int code);
    int t [8] = '{1, 2, 4, 8, 16, 64, 256, 1024};
    return t[code];
  endfunction

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] tops [3];
    logic [31:0] held;
    int n;
    int guard;

    step(3);
    rst = 1'b0;
    step(1);
    chk("R12 reset count", count_o, 0);
    chk("R12 reset stopped", 32'(stopped_o), 0);
    chk("R12 reset ovf", 32'(ovf_o), 0);

    // R2: divider sweep, 8-bit mode period 3 -> ovf spacing 4*div
    for (int c = 0; c < 8; c++) begin
      sreset();
      wr(2'd0, mkcfg(1, c, 2, 0, 0));
      wr(2'd3, 32'd3);
      enable = 1'b1;
      guard = 0;
      while (!ovf_o && guard < 5000) begin step(1); guard++; end
      n = 0;
      do begin step(1); n++; end while (!ovf_o && n < 5000);
      chk($sformatf("R2 divider code %0d spacing", c), 32'(n), 32'(4 * divof(c)));
    end

    // R1/R4/R3 up wraps for 8-bit (period 200), 16-bit, 32-bit
    tops[0] = 32'd200; tops[1] = 32'hFFFF; tops[2] = 32'hFFFF_FFFF;
    for (int m = 0; m < 3; m++) begin
      int wm;
      wm = (m == 0) ? 1 : (m == 1) ? 0 : 2;
      sreset();
      wr(2'd0, mkcfg(wm, 0, 0, 0, 0));
      wr(2'd3, 32'd200);
      wr(2'd2, tops[m] - 32'd2);
      enable = 1'b1;
      step(2);
      chk($sformatf("R1 R4 up top width %0d", wm), count_o, tops[m]);
      chk("R3 no ovf before wrap", 32'(ovf_o), 0);
      step(1);
      chk($sformatf("R1 up wrap width %0d", wm), count_o, 0);
      chk("R3 ovf at up wrap", 32'(ovf_o), 1);
      step(1);
      chk("R3 ovf single cycle", 32'(ovf_o), 0);
      chk("R3 count after wrap", count_o, 1);
      // down underflow
      enable = 1'b0;
      wr(2'd0, mkcfg(wm, 0, 0, 1, 0));
      wr(2'd2, 32'd1);
      enable = 1'b1;
      step(1);
      chk("R3 down step", count_o, 0);
      step(1);
      chk($sformatf("R3 underflow reload width %0d", wm), count_o, tops[m]);
      chk("R3 ovf at underflow", 32'(ovf_o), 1);
    end

    // R4: 8-bit count above period wraps on next up tick
    sreset();
    wr(2'd0, mkcfg(1, 0, 0, 0, 0));
    wr(2'd3, 32'd3);
    wr(2'd2, 32'd200);
    enable = 1'b1;
    step(1);
    chk("R4 above period wraps", count_o, 0);

    // R11: count write masked to width
    enable = 1'b0;
    wr(2'd2, 32'h1234);
    chk("R11 masked write 8-bit", count_o, 32'h34);
    wr(2'd0, mkcfg(0, 0, 0, 0, 0));
    wr(2'd2, 32'hABCD1234);
    chk("R11 masked write 16-bit", count_o, 32'h1234);

    // R5: one-shot up then down
    sreset();
    wr(2'd0, mkcfg(1, 0, 0, 0, 1));
    wr(2'd3, 32'd5);
    enable = 1'b1;
    guard = 0;
    while (!ovf_o && guard < 100) begin step(1); guard++; end
    chk("R5 one-shot up wrap", count_o, 0);
    chk("R5 one-shot stops", 32'(stopped_o), 1);
    step(10);
    chk("R5 one-shot holds", count_o, 0);
    wr(2'd0, mkcfg(1, 0, 0, 1, 1));
    wr(2'd1, 32'd1);
    chk("R6 retrigger down loads top", count_o, 5);
    chk("R6 retrigger clears stop", 32'(stopped_o), 0);
    guard = 0;
    while (!ovf_o && guard < 100) begin step(1); guard++; end
    chk("R5 one-shot down reload", count_o, 5);
    chk("R5 one-shot down stops", 32'(stopped_o), 1);
    step(10);
    chk("R5 one-shot down holds", count_o, 5);

    // R6/R7: stop, ignored code, retrigger up
    sreset();
    enable = 1'b1;
    step(7);
    wr(2'd1, 32'd2);
    chk("R6 stop sets status", 32'(stopped_o), 1);
    held = count_o;
    step(20);
    chk("R6 stop holds count", count_o, held);
    wr(2'd1, 32'd3);
    chk("R7 code 3 keeps stop", 32'(stopped_o), 1);
    chk("R7 code 3 keeps count", count_o, held);
    wr(2'd1, 32'd1);
    chk("R6 retrigger up loads zero", count_o, 0);
    chk("R6 retrigger up clears stop", 32'(stopped_o), 0);
    step(1);
    wr(2'd1, 32'd3);
    chk("R7 code 3 does not stop", 32'(stopped_o), 0);
    chk("R7 code 3 keeps counting", count_o, 2);

    // R10: enable low freezes
    enable = 1'b0;
    held = count_o;
    step(12);
    chk("R10 disabled holds", count_o, held);
    chk("R10 disabled no ovf", 32'(ovf_o), 0);

    // R8: sync code 1, retrigger waits for tick
    sreset();
    wr(2'd0, mkcfg(0, 4, 1, 0, 0));
    wr(2'd2, 32'd500);
    wr(2'd1, 32'd1);
    step(30);
    chk("R8 sync1 waits without tick", count_o, 500);
    enable = 1'b1;
    step(15);
    chk("R8 sync1 before tick", count_o, 500);
    step(1);
    chk("R8 sync1 loads on tick", count_o, 0);
    step(16);
    chk("R8 sync1 next step", count_o, 1);

    // R8: sync code 0, prescaler phase kept
    sreset();
    wr(2'd0, mkcfg(0, 4, 0, 0, 0));
    wr(2'd2, 32'd500);
    enable = 1'b1;
    step(5);
    wr(2'd1, 32'd1);
    chk("R8 sync0 immediate load", count_o, 0);
    step(9);
    chk("R8 sync0 phase kept before", count_o, 0);
    step(1);
    chk("R8 sync0 phase kept step", count_o, 1);

    // R8: sync code 2, prescaler phase cleared
    sreset();
    wr(2'd0, mkcfg(0, 4, 2, 0, 0));
    wr(2'd2, 32'd500);
    enable = 1'b1;
    step(5);
    wr(2'd1, 32'd1);
    chk("R8 sync2 immediate load", count_o, 0);
    step(15);
    chk("R8 sync2 phase cleared before", count_o, 0);
    step(1);
    chk("R8 sync2 full period step", count_o, 1);

    // R9: soft reset clears config and period
    sreset();
    wr(2'd0, mkcfg(1, 7, 1, 1, 1));
    wr(2'd3, 32'd77);
    wr(2'd2, 32'd9);
    wr(2'd1, 32'd2);
    sreset();
    chk("R9 count cleared", count_o, 0);
    chk("R9 stop cleared", 32'(stopped_o), 0);
    enable = 1'b1;
    step(3);
    chk("R9 defaults up 16-bit div1", count_o, 3);
    sreset();
    wr(2'd0, mkcfg(1, 0, 0, 0, 0));
    enable = 1'b1;
    step(3);
    chk("R9 period cleared count", count_o, 0);
    chk("R9 period cleared ovf", 32'(ovf_o), 1);

    done = 1;
    summary();
    $finish;
  end

endmodule